// File: doc/BRIEF.md
# Variant-Configurable System Control Register Bank

This block is a bank of 32-bit control and status registers behind a simple single-cycle register bus. The bank decodes a 4 KB window. A static parameter selects one of three variants (0, 1 or 2), and that choice decides which word offsets exist, which register an offset reaches, and which access rules apply. The bank holds the following:

- a secure-debug status word, with separate set and clear aliases;
- reset-cause, reset-mask and retention words;
- a software reset trigger;
- initial vector-table address words, with an optional write lock;
- per-CPU hold bits;
- clock-divider, clock-force and security-control words;
- a self-locking power-control word;
- power-domain sense words;
- fixed identification bytes.

The bank drives three kinds of side-band outputs. It raises a one-cycle system reset request. It raises a one-cycle boot-release strobe for each CPU whose hold bit a write clears. It presents the vector-table start address for each CPU continuously. Clock generation, the CPU resets themselves and power sequencing happen outside this block.

A write takes effect on the clock edge at which `bus_sel` and `bus_wr` are both high. A read returns data in the same cycle that `bus_sel` is high and `bus_wr` is low. The bus has no wait states and no error response.

Top module: `sysctl_bank`

## Requirements
- R1: Reset values are as follows. Status word 0x000 = 0. Reset cause 0x100 = 1. Power control 0x1FC = 0x3. System sense 0x200 = 0x7F. Both vector-table words = VTOR_RST (default 0x1000_0000). Hold bits = HOLD_RST (default 0). Every other stored word = 0. After reset `sys_rst_req` and `cpu_release` are 0.
- R2: The status word at 0x000 ignores direct writes. A write to 0x004 ORs the write data into it. A write to 0x008 clears every bit written as 1.
- R3: Offsets 0x004, 0x008 and 0x108 are write-only and read as 0.
- R4: A write to 0x108 with bit 9 set raises `sys_rst_req` for exactly the next cycle. A write to 0x108 with bit 9 clear raises nothing, whatever the other bits hold.
- R5: The vector-table word for CPU 0 is at 0x110.
  - In variant 2, bit 0 of this word is a lock: once it reads 1, writes are dropped. `cpu_vtor0` shows bits 31:7 of the word, with bits 6:0 forced to 0.
  - In variants 0 and 1, the whole word is writable and `cpu_vtor0` shows it unmasked.
  - The word at 0x114 exists only in variant 1. `cpu_vtor1` shows the 0x114 word in variants 0 and 1, and shows 0 in variant 2.
- R6: The power-control word at 0x1FC exists only in variant 2. It accepts a write only while its bit 0 reads 1.
- R7: The hold word is at 0x118 in variants 0 and 1, where bits 1:0 cover two CPUs. It is at 0x120 in variant 2, where bit 0 covers one CPU. A write that changes a covered bit from 1 to 0 raises the matching `cpu_release` bit for exactly the next cycle. No other write raises it.
- R8: Offset remapping depends on the variant:
  - Variant 1: 0x11C is NMI-enable, 0x120 is wake-interrupt control, and 0x124 is external-wake control.
  - Variant 2: 0x124 is NMI-enable, and 0x118 and 0x11C are absent.
  - Variant 0: 0x11C reads 0 and ignores writes, 0x120 is wake-interrupt control, and 0x124 is absent.
- R9: Offsets 0x00C to 0x018 and 0x200 are absent in variant 0. Other sense words exist only in certain variants: 0x204 in variant 2 only, 0x20C and 0x210 in variant 1 only, and 0x214 and 0x218 in variants 1 and 2.
- R10: Offsets 0xFD0 to 0xFFC read fixed bytes, in address order: 04 00 00 00, 54 B8 xx 00, 0D F0 05 B1. The byte xx is 0x0B in variant 0 and 0x1B otherwise. Writes to these offsets are ignored.
- R11: An absent or undefined offset reads as 0, and a write to it changes no register.
- R12: Address bits 1:0 are ignored, so a narrow access acts on the whole word that contains it. Read data is valid in the cycle of the request. Write data is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not reading |
| sys_rst_req | output | 1 | One-cycle system reset request |
| cpu_release | output | 2 | One-cycle boot-release strobe per CPU |
| cpu_vtor0 | output | 32 | Vector-table address for CPU 0 |
| cpu_vtor1 | output | 32 | Vector-table address for CPU 1 |

## Verification
The properties assume that `bus_sel` is the only qualifier of an access and that `bus_addr`, `bus_wr` and `bus_wdata` hold steady for the whole cycle of a request. They also assume that the bus never issues a read and a write in the same cycle. The bench meets these assumptions by changing bus inputs only on falling edges and by running one access per task call, with `bus_sel` dropped between calls. All three variants are instantiated on one shared bus, so every access compares how each variant decodes the same offset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int WIDX_W  = ADDR_W - 2;
    localparam int CPU_MAX = 2;

    // storage slot numbering (internal only)
    localparam int SL_DBG       = 0;
    localparam int SL_SECCTL    = 1;
    localparam int SL_FDIV      = 2;
    localparam int SL_SDIV      = 3;
    localparam int SL_CFORCE    = 4;
    localparam int SL_RCAUSE    = 5;
    localparam int SL_RMASK     = 6;
    localparam int SL_RETAIN    = 7;
    localparam int SL_VTOR0     = 8;
    localparam int SL_VTOR1     = 9;
    localparam int SL_HOLD      = 10;
    localparam int SL_NMI       = 11;
    localparam int SL_WAKEI     = 12;
    localparam int SL_EWAKE     = 13;
    localparam int SL_PWR       = 14;
    localparam int SL_SNS_SYS   = 15;
    localparam int SL_SNS_CPU0  = 16;
    localparam int SL_SNS_SRAM0 = 17;
    localparam int SL_SNS_SRAM1 = 18;
    localparam int SL_SNS_A     = 19;
    localparam int SL_SNS_B     = 20;
    localparam int SLOT_N       = 21;
    localparam int SLOT_W       = $clog2(SLOT_N);

    // bit positions that neighbours act on
    localparam int SWRST_BIT   = 9;
    localparam int LOCK_BIT    = 0;
    localparam int VTOR_LSB    = 7;
    localparam int UNLOCK_BIT  = 0;

    localparam logic [WIDX_W-1:0] W_SWRST    = 10'h042;
    localparam logic [WIDX_W-1:0] W_ID_FIRST = 10'h3F4;

    typedef enum logic [2:0] {
        AK_NONE,
        AK_STORE,
        AK_STATUS,
        AK_DBG_SET,
        AK_DBG_CLR,
        AK_SWRST,
        AK_IDWORD
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e         kind;
        logic [SLOT_W-1:0] slot;
        logic [3:0]        id_idx;
    } dec_t;

    function automatic int cpu_count(input int variant);
        return (variant == 2) ? 1 : 2;
    endfunction

    function automatic logic [WORD_W-1:0] slot_reset(input int slot,
                                                     input logic [WORD_W-1:0] vtor_rst,
                                                     input logic [WORD_W-1:0] hold_rst);
        case (slot)
            SL_RCAUSE:          return 32'h0000_0001;
            SL_PWR:             return 32'h0000_0003;
            SL_SNS_SYS:         return 32'h0000_007F;
            SL_VTOR0, SL_VTOR1: return vtor_rst;
            SL_HOLD:            return hold_rst;
            default:            return '0;
        endcase
    endfunction

    function automatic logic [7:0] id_byte(input int variant, input logic [3:0] idx);
        case (idx)
            4'd0:    return 8'h04;
            4'd4:    return 8'h54;
            4'd5:    return 8'hB8;
            4'd6:    return (variant == 0) ? 8'h0B : 8'h1B;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

    function automatic dec_t mk(input acc_kind_e k, input int slot);
        dec_t d;
        d.kind   = k;
        d.slot   = SLOT_W'(slot);
        d.id_idx = '0;
        return d;
    endfunction

    // word index -> access kind and slot, per variant
    function automatic dec_t decode_word(input int variant, input logic [WIDX_W-1:0] w);
        dec_t d;
        d = mk(AK_NONE, 0);
        case (w)
            10'h000: d = mk(AK_STATUS, SL_DBG);
            10'h001: d = mk(AK_DBG_SET, 0);
            10'h002: d = mk(AK_DBG_CLR, 0);
            10'h003: if (variant != 0) d = mk(AK_STORE, SL_SECCTL);
            10'h004: if (variant != 0) d = mk(AK_STORE, SL_FDIV);
            10'h005: if (variant != 0) d = mk(AK_STORE, SL_SDIV);
            10'h006: if (variant != 0) d = mk(AK_STORE, SL_CFORCE);
            10'h040: d = mk(AK_STORE, SL_RCAUSE);
            10'h041: d = mk(AK_STORE, SL_RMASK);
            10'h042: d = mk(AK_SWRST, 0);
            10'h043: d = mk(AK_STORE, SL_RETAIN);
            10'h044: d = mk(AK_STORE, SL_VTOR0);
            10'h045: if (variant == 1) d = mk(AK_STORE, SL_VTOR1);
            10'h046: if (variant != 2) d = mk(AK_STORE, SL_HOLD);
            10'h047: if (variant == 1) d = mk(AK_STORE, SL_NMI);
            10'h048: d = (variant == 2) ? mk(AK_STORE, SL_HOLD) : mk(AK_STORE, SL_WAKEI);
            10'h049: begin
                if (variant == 1)      d = mk(AK_STORE, SL_EWAKE);
                else if (variant == 2) d = mk(AK_STORE, SL_NMI);
            end
            10'h07F: if (variant == 2) d = mk(AK_STORE, SL_PWR);
            10'h080: if (variant != 0) d = mk(AK_STORE, SL_SNS_SYS);
            10'h081: if (variant == 2) d = mk(AK_STORE, SL_SNS_CPU0);
            10'h083: if (variant == 1) d = mk(AK_STORE, SL_SNS_SRAM0);
            10'h084: if (variant == 1) d = mk(AK_STORE, SL_SNS_SRAM1);
            10'h085: if (variant != 0) d = mk(AK_STORE, SL_SNS_A);
            10'h086: if (variant != 0) d = mk(AK_STORE, SL_SNS_B);
            default: begin
                if (w >= W_ID_FIRST) begin
                    d.kind   = AK_IDWORD;
                    d.id_idx = 4'(w - W_ID_FIRST);
                end
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int VARIANT = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    // byte-lane bits do not take part in decode
    logic unused_lane;
    assign unused_lane = ^addr[1:0];

    always_comb begin
        dec = decode_word(VARIANT, addr[ADDR_W-1:2]);
    end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int                VARIANT  = 1,
    parameter logic [WORD_W-1:0] VTOR_RST = 32'h1000_0000,
    parameter logic [WORD_W-1:0] HOLD_RST = '0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  dec_t                         dec,
    input  logic [WORD_W-1:0]            wdata,
    output logic [SLOT_N-1:0][WORD_W-1:0] slots
);
    logic unused_idx;
    assign unused_idx = ^dec.id_idx;

    logic vtor_locked;
    logic pwr_locked;
    assign vtor_locked = (VARIANT == 2) && slots[SL_VTOR0][LOCK_BIT];
    assign pwr_locked  = !slots[SL_PWR][UNLOCK_BIT];

    for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
        localparam logic [WORD_W-1:0] RST_V = slot_reset(s, VTOR_RST, HOLD_RST);
        logic [WORD_W-1:0] r;
        logic              hit;
        logic              gate;

        assign slots[s] = r;
        assign hit      = wr_en && (dec.kind == AK_STORE) && (dec.slot == SLOT_W'(s));

        if (s == SL_VTOR0) begin : g_vtor_gate
            assign gate = !vtor_locked;
        end else if (s == SL_PWR) begin : g_pwr_gate
            assign gate = !pwr_locked;
        end else begin : g_open
            assign gate = 1'b1;
        end

        if (s == SL_DBG) begin : g_setclr
            always_ff @(posedge clk) begin
                if (rst) begin
                    r <= RST_V;
                end else if (wr_en && dec.kind == AK_DBG_SET) begin
                    r <= r | wdata;
                end else if (wr_en && dec.kind == AK_DBG_CLR) begin
                    r <= r & ~wdata;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) begin
                    r <= RST_V;
                end else if (hit && gate) begin
                    r <= wdata;
                end
            end
        end
    end
endmodule

// File: rtl/sysctl_release.sv
module sysctl_release
    import sysctl_pkg::*;
#(
    parameter int VARIANT = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold_we,
    input  logic [CPU_MAX-1:0] hold_q,
    input  logic [CPU_MAX-1:0] hold_new,
    output logic [CPU_MAX-1:0] release_o
);
    localparam int CPU_N = cpu_count(VARIANT);

    for (genvar c = 0; c < CPU_MAX; c++) begin : g_cpu
        logic r;
        assign release_o[c] = r;
        if (c < CPU_N) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) r <= 1'b0;
                else     r <= hold_we && hold_q[c] && !hold_new[c];
            end
        end else begin : g_absent
            logic unused_bits;
            assign unused_bits = hold_q[c] ^ hold_new[c];
            assign r = 1'b0;
        end
    end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int                 VARIANT  = 1,
    parameter logic [WORD_W-1:0]  VTOR_RST = 32'h1000_0000,
    parameter logic [CPU_MAX-1:0] HOLD_RST = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               sys_rst_req,
    output logic [CPU_MAX-1:0] cpu_release,
    output logic [WORD_W-1:0]  cpu_vtor0,
    output logic [WORD_W-1:0]  cpu_vtor1
);
    if (VARIANT < 0 || VARIANT > 2) begin : g_bad_variant
        $error("sysctl_bank: VARIANT must be 0, 1 or 2");
    end

    dec_t                          dec;
    logic                          wr_en;
    logic [SLOT_N-1:0][WORD_W-1:0] slots;
    logic                          hold_we;
    logic [WORD_W-1:0]             rd_word;

    assign wr_en = bus_sel && bus_wr;

    sysctl_decode #(.VARIANT(VARIANT)) u_decode (
        .addr (bus_addr),
        .dec  (dec)
    );

    sysctl_store #(
        .VARIANT  (VARIANT),
        .VTOR_RST (VTOR_RST),
        .HOLD_RST (WORD_W'(HOLD_RST))
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .dec   (dec),
        .wdata (bus_wdata),
        .slots (slots)
    );

    assign hold_we = wr_en && (dec.kind == AK_STORE) && (dec.slot == SLOT_W'(SL_HOLD));

    sysctl_release #(.VARIANT(VARIANT)) u_release (
        .clk       (clk),
        .rst       (rst),
        .hold_we   (hold_we),
        .hold_q    (slots[SL_HOLD][CPU_MAX-1:0]),
        .hold_new  (bus_wdata[CPU_MAX-1:0]),
        .release_o (cpu_release)
    );

    always_ff @(posedge clk) begin
        if (rst) sys_rst_req <= 1'b0;
        else     sys_rst_req <= wr_en && (dec.kind == AK_SWRST) && bus_wdata[SWRST_BIT];
    end

    always_comb begin
        rd_word = '0;
        case (dec.kind)
            AK_STORE, AK_STATUS: begin
                for (int s = 0; s < SLOT_N; s++) begin
                    if (dec.slot == SLOT_W'(s)) rd_word = slots[s];
                end
            end
            AK_IDWORD: rd_word = {{(WORD_W-8){1'b0}}, id_byte(VARIANT, dec.id_idx)};
            default:   rd_word = '0;
        endcase
    end

    assign bus_rdata = (bus_sel && !bus_wr) ? rd_word : '0;

    if (VARIANT == 2) begin : g_vtor_masked
        assign cpu_vtor0 = {slots[SL_VTOR0][WORD_W-1:VTOR_LSB], {VTOR_LSB{1'b0}}};
        assign cpu_vtor1 = '0;
    end else begin : g_vtor_full
        assign cpu_vtor0 = slots[SL_VTOR0];
        assign cpu_vtor1 = slots[SL_VTOR1];
    end
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk
    import sysctl_pkg::*;
#(
    parameter int VARIANT = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [WORD_W-1:0]  bus_wdata,
    input logic [WORD_W-1:0]  bus_rdata,
    input logic               sys_rst_req,
    input logic [CPU_MAX-1:0] cpu_release,
    input logic [WORD_W-1:0]  cpu_vtor0
);
    localparam logic [WIDX_W-1:0] W_HOLD  = (VARIANT == 2) ? 10'h048 : 10'h046;
    localparam logic [WIDX_W-1:0] W_VTOR0 = 10'h044;

    logic [WIDX_W-1:0] w;
    logic              rd_req;
    logic              wr_req;
    assign w      = bus_addr[ADDR_W-1:2];
    assign rd_req = bus_sel && !bus_wr;
    assign wr_req = bus_sel && bus_wr;

    a_r4_pulse_follows: assert property (@(posedge clk) disable iff (rst)
        (wr_req && w == W_SWRST && bus_wdata[SWRST_BIT]) |=> sys_rst_req);

    a_r4_no_stray_pulse: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && w == W_SWRST && bus_wdata[SWRST_BIT]) |=> !sys_rst_req);

    a_r7_release_needs_write: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && w == W_HOLD) |=> (cpu_release == '0));

    a_r7_single_cpu: assert property (@(posedge clk) disable iff (rst)
        (VARIANT == 2) |-> !cpu_release[1]);

    a_r5_vtor_held: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && w == W_VTOR0) |=> $stable(cpu_vtor0));

    a_r5_vtor_aligned: assert property (@(posedge clk) disable iff (rst)
        (VARIANT == 2) |-> (cpu_vtor0[VTOR_LSB-1:0] == '0));

    a_r3_write_only_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_req && (w == 10'h001 || w == 10'h002 || w == W_SWRST)) |-> (bus_rdata == '0));

    a_r11_hole_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_req && w >= 10'h0C0 && w < W_ID_FIRST) |-> (bus_rdata == '0));

    a_r10_id_tail: assert property (@(posedge clk) disable iff (rst)
        (rd_req && w == 10'h3FF) |-> (bus_rdata == 32'h0000_00B1));
endmodule

bind sysctl_bank sysctl_bank_chk #(.VARIANT(VARIANT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sys_rst_req (sys_rst_req),
    .cpu_release (cpu_release),
    .cpu_vtor0   (cpu_vtor0)
);

// File: tb/sysctl_bank_tb.sv
`timescale 1ns/1ps
module sysctl_bank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr  = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;

    logic [31:0] rd0, rd1, rd2;
    logic        sr0, sr1, sr2;
    logic [1:0]  rel0, rel1, rel2;
    logic [31:0] va0, va1, va2;
    logic [31:0] vb0, vb1, vb2;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] r0, r1, r2;

    always #2.5 clk = ~clk;

    sysctl_bank #(.VARIANT(0)) u_dut_v0 (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rd0), .sys_rst_req(sr0), .cpu_release(rel0), .cpu_vtor0(va0), .cpu_vtor1(vb0));
    sysctl_bank #(.VARIANT(1)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rd1), .sys_rst_req(sr1), .cpu_release(rel1), .cpu_vtor0(va1), .cpu_vtor1(vb1));
    sysctl_bank #(.VARIANT(2)) u_dut_v2 (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rd2), .sys_rst_req(sr2), .cpu_release(rel2), .cpu_vtor0(va2), .cpu_vtor1(vb2));

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] e0;
        logic [31:0] e1;
        logic [31:0] e2;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 32'h0,         32'h0,         32'h0,         32'h0,         "R1 "},
        '{1'b0, 12'h100, 32'h0,         32'h1,         32'h1,         32'h1,         "R1 "},
        '{1'b0, 12'h110, 32'h0,         32'h1000_0000, 32'h1000_0000, 32'h1000_0000, "R1 "},
        '{1'b0, 12'h114, 32'h0,         32'h0,         32'h1000_0000, 32'h0,         "R5 "},
        '{1'b0, 12'h1FC, 32'h0,         32'h0,         32'h0,         32'h3,         "R1 "},
        '{1'b0, 12'h200, 32'h0,         32'h0,         32'h7F,        32'h7F,        "R9 "},
        '{1'b0, 12'hFD0, 32'h0,         32'h04,        32'h04,        32'h04,        "R10"},
        '{1'b0, 12'hFE8, 32'h0,         32'h0B,        32'h1B,        32'h1B,        "R10"},
        '{1'b0, 12'hFF0, 32'h0,         32'h0D,        32'h0D,        32'h0D,        "R10"},
        '{1'b0, 12'hFFC, 32'h0,         32'hB1,        32'hB1,        32'hB1,        "R10"},
        '{1'b1, 12'h00C, 32'hA5A5_0001, 32'h0,         32'hA5A5_0001, 32'hA5A5_0001, "R9 "},
        '{1'b1, 12'h11C, 32'h1,         32'h0,         32'h1,         32'h0,         "R8 "},
        '{1'b1, 12'h124, 32'h77,        32'h0,         32'h77,        32'h77,        "R8 "},
        '{1'b1, 12'h114, 32'h2000_0080, 32'h0,         32'h2000_0080, 32'h0,         "R5 "},
        '{1'b1, 12'h1FC, 32'h2,         32'h0,         32'h0,         32'h2,         "R6 "},
        '{1'b1, 12'h1FC, 32'h3,         32'h0,         32'h0,         32'h2,         "R6 "},
        '{1'b1, 12'h110, 32'h2000_0081, 32'h2000_0081, 32'h2000_0081, 32'h2000_0081, "R5 "},
        '{1'b1, 12'h110, 32'h3000_0000, 32'h3000_0000, 32'h3000_0000, 32'h2000_0081, "R5 "},
        '{1'b1, 12'hFF0, 32'hFFFF_FFFF, 32'h0D,        32'h0D,        32'h0D,        "R10"},
        '{1'b1, 12'h004, 32'hFF,        32'h0,         32'h0,         32'h0,         "R3 "},
        '{1'b1, 12'h300, 32'hDEAD_BEEF, 32'h0,         32'h0,         32'h0,         "R11"},
        '{1'b1, 12'h218, 32'h55,        32'h0,         32'h55,        32'h55,        "R9 "},
        '{1'b1, 12'h20C, 32'h66,        32'h0,         32'h66,        32'h0,         "R9 "},
        '{1'b1, 12'h204, 32'h44,        32'h0,         32'h0,         32'h44,        "R9 "}
    };

    task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", msg, act, exp);
        end
    endtask

    task automatic chk3(input string msg, input logic [31:0] e0, input logic [31:0] e1,
                        input logic [31:0] e2);
        chk({msg, " v0"}, r0, e0);
        chk({msg, " v1"}, r1, e1);
        chk({msg, " v2"}, r2, e2);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        r0 = rd0; r1 = rd1; r2 = rd2;
        sel = 1'b0;
    endtask

    task automatic grab_release;
        r0 = {30'b0, rel0}; r1 = {30'b0, rel1}; r2 = {30'b0, rel2};
    endtask

    task automatic grab_rstreq;
        r0 = {31'b0, sr0}; r1 = {31'b0, sr1}; r2 = {31'b0, sr2};
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: outputs right after reset
        grab_rstreq();  chk3("R1 reset request idle", 0, 0, 0);
        grab_release(); chk3("R1 release idle", 0, 0, 0);
        r0 = va0; r1 = va1; r2 = va2;
        chk3("R1 vtor0 reset", 32'h1000_0000, 32'h1000_0000, 32'h1000_0000);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].wdata);
            bus_read(VECS[i].addr);
            chk3($sformatf("%s table %0d addr %h", VECS[i].tag, i, VECS[i].addr),
                 VECS[i].e0, VECS[i].e1, VECS[i].e2);
        end

        // R5: exported addresses after table writes
        r0 = va0; r1 = va1; r2 = va2;
        chk3("R5 vtor0 export", 32'h3000_0000, 32'h3000_0000, 32'h2000_0080);
        r0 = vb0; r1 = vb1; r2 = vb2;
        chk3("R5 vtor1 export", 32'h1000_0000, 32'h2000_0080, 32'h0);

        // R2: set/clear aliases, status ignores direct write (0xFF was set by table)
        bus_write(12'h008, 32'hFFFF_FFFF);
        bus_read(12'h000); chk3("R2 clear all", 0, 0, 0);
        bus_write(12'h004, 32'h0000_00F0);
        bus_read(12'h000); chk3("R2 set", 32'hF0, 32'hF0, 32'hF0);
        bus_write(12'h008, 32'h0000_0030);
        bus_read(12'h000); chk3("R2 clear some", 32'hC0, 32'hC0, 32'hC0);
        bus_write(12'h000, 32'h0000_00FF);
        bus_read(12'h000); chk3("R2 direct write ignored", 32'hC0, 32'hC0, 32'hC0);
        bus_read(12'h008); chk3("R3 clear alias reads zero", 0, 0, 0);

        // R4: software reset request
        bus_write(12'h108, 32'h0000_0200);
        grab_rstreq(); chk3("R4 request pulse", 1, 1, 1);
        @(negedge clk);
        grab_rstreq(); chk3("R4 pulse one cycle", 0, 0, 0);
        bus_write(12'h108, 32'hFFFF_FDFF);
        grab_rstreq(); chk3("R4 other bits ignored", 0, 0, 0);
        bus_read(12'h108); chk3("R3 reset trigger reads zero", 0, 0, 0);

        // R7: hold bits and release strobes
        bus_write(12'h118, 32'h3);
        grab_release(); chk3("R7 set hold no strobe", 0, 0, 0);
        bus_write(12'h118, 32'h1);
        grab_release(); chk3("R7 cpu1 released at 0x118", 2, 2, 0);
        @(negedge clk);
        grab_release(); chk3("R7 strobe one cycle", 0, 0, 0);
        bus_write(12'h120, 32'h1);
        grab_release(); chk3("R7 v2 hold set", 0, 0, 0);
        bus_write(12'h120, 32'h0);
        grab_release(); chk3("R8 0x120 releases only in v2", 0, 0, 1);
        bus_read(12'h118); chk3("R8 0x118 hold readback", 1, 1, 0);
        bus_write(12'h118, 32'h0);
        grab_release(); chk3("R7 cpu0 released", 1, 1, 0);

        // R12: byte-lane bits ignored
        bus_write(12'h10D, 32'h0000_005A);
        bus_read(12'h10C); chk3("R12 narrow write word", 32'h5A, 32'h5A, 32'h5A);
        bus_read(12'h10F); chk3("R12 narrow read", 32'h5A, 32'h5A, 32'h5A);

        // R11: undefined write leaves registers alone
        bus_write(12'h7F0, 32'hFFFF_FFFF);
        bus_read(12'h10C); chk3("R11 retention untouched", 32'h5A, 32'h5A, 32'h5A);
        bus_read(12'h7F0); chk3("R11 hole reads zero", 0, 0, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule